// File: doc/BRIEF.md
# Serial Port with Buffered Transmit and Receive

This block is an asynchronous serial transceiver that sits on a 32-bit register bus with APB-style timing. Software sees four word registers: a data port, a status word, a control word and a bit-rate divider. A write to the data port queues a byte in a transmit FIFO. A read of the data port returns the oldest received byte and removes it from the receive FIFO. The status word packs both FIFO occupancy counts next to empty, half and full flags, and sticky error bits. A write of any value to the status word clears the sticky bits.

Inside the block, data moves as a stream. The transmit FIFO offers a byte to the serializer with valid/ready, and the serializer takes it only when its shift register is idle. The FIFO therefore holds bytes for as long as the transmitter is disabled or busy. The deserializer offers each finished frame with a one-cycle valid. The receive FIFO cannot push back. A frame that finds it full is discarded and reported as an overrun. A loopback mode sends the serial output straight to the receiver for self-test. While loopback is set, the external serial output rests at idle.

Top module: `uart_fifo_periph`

## Requirements
- R1: After reset the status word reads 0x0000_0086: the shift register is empty (bit 1), the transmit FIFO is empty (bit 2) and the transmit FIFO is at or below half (bit 7). The serial output is 1 and the interrupt is 0.
- R2: The control word at offset 0x8 keeps bits 0-7, 9 and 10 and reads the other bits as 0, so a write of 0xFFF reads back as 0x6FF. The divider at offset 0xC reads back the value written to it.
- R3: While control bit 1 (transmit enable) is 0, each data write (offset 0x0) adds one entry and the transmit count (status bits 25:20) rises by one. Nothing is sent and the serial output stays 1. At DEPTH entries, status bit 9 (transmit full) is set, and any further write is dropped.
- R4: A frame is one start bit (0), eight data bits LSB first, a parity bit when control bit 5 is set, and one stop bit (1). Each bit lasts 8×(divider+1) clock cycles. The parity bit makes the count of ones even when control bit 4 is 0, and odd when it is 1.
- R5: With control bit 7 (loopback) set, transmitted frames reach the receiver in order. The external serial output stays 1.
- R6: Reading the data port returns the oldest received byte, lowers the receive count (status bits 31:26) by one and clears status bit 0 once the FIFO is empty. A read of an empty FIFO returns 0.
- R7: Status bit 7 is set while the transmit count is at most DEPTH/2. Bit 8 is set while the receive count is at least DEPTH/2. Bit 10 is set while the receive count equals DEPTH.
- R8: A frame that completes while the receive FIFO is full is dropped and sets the sticky overrun bit (status bit 4). Any write to the status word (offset 0x4) clears bits 4, 5 and 6.
- R9: With parity enabled, a frame whose parity is wrong is stored and sets sticky bit 5. A frame whose stop bit samples 0 is not stored and sets sticky bit 6.
- R10: While control bit 0 (receive enable) is 0, incoming frames are ignored and the receive count stays 0.
- R11: The interrupt output goes high when any of these holds: control bit 2 is set and a frame is received (one cycle), control bit 3 is set and a frame finishes sending (one cycle), control bit 9 is set and status bit 7 holds, or control bit 10 is set and status bit 8 holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | Register select |
| penable | input | 1 | Access phase |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 4 | Byte offset of the register |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid during the access phase |
| rxd | input | 1 | Serial input |
| txd | output | 1 | Serial output |
| irq | output | 1 | Interrupt request |

## Verification
The loopback path is driven with a table of bytes that covers all zeros, all ones, alternating bits and single set bits at each end. The table is run with parity off, even and odd. A lost, reordered or bit-swapped byte shows up as a mismatch. A parity setting that the sender and receiver handle differently shows up as a spurious error bit. The serial output is also sampled at the middle of each bit of an external frame, which checks bit order, parity polarity and bit timing that loopback alone cannot reveal. Frames driven into the serial input with wrong parity, a low stop bit, the receiver disabled or a full FIFO separate the error, drop and overrun paths from normal reception.

// File: rtl/uart_fifo_pkg.sv
package uart_fifo_pkg;
  typedef enum logic [2:0] {SER_IDLE, SER_START, SER_DATA, SER_PAR, SER_STOP} ser_state_e;

  localparam int OVS      = 8;                 // ticks per bit
  localparam int PH_W     = $clog2(OVS);
  localparam int CTRL_W   = 11;
  localparam logic [CTRL_W-1:0] CTRL_KEEP = 11'h6FF;

  // control bit positions
  localparam int C_RXEN = 0;
  localparam int C_TXEN = 1;
  localparam int C_RIE  = 2;
  localparam int C_TIE  = 3;
  localparam int C_ODD  = 4;
  localparam int C_PEN  = 5;
  localparam int C_LOOP = 7;
  localparam int C_TFIE = 9;
  localparam int C_RFIE = 10;

  // register offsets
  localparam logic [3:0] A_DATA = 4'h0;
  localparam logic [3:0] A_STAT = 4'h4;
  localparam logic [3:0] A_CTRL = 4'h8;
  localparam logic [3:0] A_DIV  = 4'hC;
endpackage

// File: rtl/uart_fifo_buf.sv
module uart_fifo_buf #(
  parameter int W     = 8,
  parameter int DEPTH = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         push,
  input  logic [W-1:0]                 wdata,
  input  logic                         pop,
  output logic [W-1:0]                 rdata,
  output logic [$clog2(DEPTH+1)-1:0]   count,
  output logic                         full,
  output logic                         empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH+1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic          do_push, do_pop;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH-1)) ? '0 : p + 1'b1;
  endfunction

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push & ~full;
  assign do_pop  = pop & ~empty;
  assign rdata   = mem[rp];

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; count <= '0;
    end else begin
      if (do_push) wp <= nxt(wp);
      if (do_pop)  rp <= nxt(rp);
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop) |=> (count == $past(count))); // R3
  AST_POP_DEC: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !empty && !push) |=> (count == $past(count) - 1'b1)); // R6
endmodule

// File: rtl/uart_tx_ser.sv
module uart_tx_ser
  import uart_fifo_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic [7:0] in_data,
  input  logic       par_en,
  input  logic       odd,
  output logic       txd,
  output logic       done
);
  localparam logic [PH_W-1:0] LAST = PH_W'(OVS-1);

  ser_state_e      state;
  logic [7:0]      sh;
  logic [2:0]      bitn;
  logic [PH_W-1:0] ph;
  logic            pbit;

  assign in_ready = (state == SER_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= SER_IDLE; sh <= '0; bitn <= '0; ph <= '0; pbit <= 1'b0; done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (in_valid && in_ready) begin
        state <= SER_START; sh <= in_data; ph <= '0; bitn <= '0;
        pbit  <= (^in_data) ^ odd;
      end else if (tick && state != SER_IDLE) begin
        ph <= ph + 1'b1;
        if (ph == LAST) begin
          unique case (state)
            SER_START: begin state <= SER_DATA; bitn <= '0; end
            SER_DATA: begin
              sh   <= {1'b0, sh[7:1]};
              bitn <= bitn + 1'b1;
              if (bitn == 3'd7) state <= par_en ? SER_PAR : SER_STOP;
            end
            SER_PAR:  state <= SER_STOP;
            SER_STOP: begin state <= SER_IDLE; done <= 1'b1; end
            default:  state <= SER_IDLE;
          endcase
        end
      end
    end
  end

  always_comb begin
    unique case (state)
      SER_START: txd = 1'b0;
      SER_DATA:  txd = sh[0];
      SER_PAR:   txd = pbit;
      default:   txd = 1'b1;
    endcase
  end

  AST_TX_DONE_AFTER_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (state == SER_IDLE && $past(state) == SER_STOP)); // R4
endmodule

// File: rtl/uart_rx_ser.sv
module uart_rx_ser
  import uart_fifo_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       en,
  input  logic       line,
  input  logic       par_en,
  input  logic       odd,
  output logic       out_valid,
  output logic [7:0] out_data,
  output logic       par_err,
  output logic       frm_err
);
  localparam logic [PH_W-1:0] LAST = PH_W'(OVS-1);
  localparam logic [PH_W-1:0] MID  = PH_W'(OVS/2-1);

  ser_state_e      state;
  logic [7:0]      sh;
  logic [2:0]      bitn;
  logic [PH_W-1:0] ph;
  logic            pbit;

  assign out_data = sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= SER_IDLE; sh <= '0; bitn <= '0; ph <= '0; pbit <= 1'b0;
      out_valid <= 1'b0; par_err <= 1'b0; frm_err <= 1'b0;
    end else begin
      out_valid <= 1'b0; par_err <= 1'b0; frm_err <= 1'b0;
      if (!en) begin
        state <= SER_IDLE;
      end else if (tick) begin
        unique case (state)
          SER_IDLE: if (!line) begin state <= SER_START; ph <= '0; end
          SER_START: begin
            if (ph == MID) begin
              ph <= '0; bitn <= '0;
              state <= line ? SER_IDLE : SER_DATA;
            end else ph <= ph + 1'b1;
          end
          SER_DATA: begin
            ph <= ph + 1'b1;
            if (ph == LAST) begin
              sh   <= {line, sh[7:1]};
              bitn <= bitn + 1'b1;
              if (bitn == 3'd7) state <= par_en ? SER_PAR : SER_STOP;
            end
          end
          SER_PAR: begin
            ph <= ph + 1'b1;
            if (ph == LAST) begin pbit <= line; state <= SER_STOP; end
          end
          SER_STOP: begin
            ph <= ph + 1'b1;
            if (ph == LAST) begin
              state <= SER_IDLE;
              if (line) begin
                out_valid <= 1'b1;
                par_err   <= par_en & (((^sh) ^ pbit) != odd);
              end else begin
                frm_err <= 1'b1;
              end
            end
          end
          default: state <= SER_IDLE;
        endcase
      end
    end
  end

  AST_RX_VALID_AFTER_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (state == SER_IDLE && $past(state) == SER_STOP)); // R5
  AST_RX_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_valid && frm_err)); // R9
endmodule

// File: rtl/uart_fifo_periph.sv
module uart_fifo_periph
  import uart_fifo_pkg::*;
#(
  parameter int DEPTH    = 8,
  parameter int SCALER_W = 12
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        psel,
  input  logic        penable,
  input  logic        pwrite,
  input  logic [3:0]  paddr,
  input  logic [31:0] pwdata,
  output logic [31:0] prdata,
  input  logic        rxd,
  output logic        txd,
  output logic        irq
);
  localparam int CW = $clog2(DEPTH+1);

  logic [CTRL_W-1:0]   ctrl_q;
  logic [SCALER_W-1:0] div_q, div_cnt;
  logic                tick;
  logic                wr, rd;
  logic                st_ovr, st_perr, st_ferr;

  logic [7:0]    tf_rdata, rf_rdata;
  logic [CW-1:0] tf_cnt, rf_cnt;
  logic          tf_full, tf_empty, rf_full, rf_empty;
  logic          tx_valid, tx_ready, tx_line, tx_done;
  logic          rx_valid, rx_perr, rx_ferr;
  logic [7:0]    rx_data;
  logic          rx_src, rx_s1, rx_s2;
  logic [31:0]   stat;
  logic          tx_half, rx_half;
  logic          unused_bits;

  assign unused_bits = ^pwdata[31:12];

  assign wr = psel & penable & pwrite;
  assign rd = psel & penable & ~pwrite;

  // bit-rate tick: one every div_q+1 cycles
  assign tick = (div_cnt == '0);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    div_cnt <= '0;
    else if (tick) div_cnt <= div_q;
    else           div_cnt <= div_cnt - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0; div_q <= '0;
    end else if (wr) begin
      if (paddr == A_CTRL) ctrl_q <= pwdata[CTRL_W-1:0] & CTRL_KEEP;
      if (paddr == A_DIV)  div_q  <= pwdata[SCALER_W-1:0];
    end
  end

  uart_fifo_buf #(.W(8), .DEPTH(DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n),
    .push(wr && paddr == A_DATA), .wdata(pwdata[7:0]),
    .pop(tx_valid & tx_ready), .rdata(tf_rdata),
    .count(tf_cnt), .full(tf_full), .empty(tf_empty));

  assign tx_valid = ctrl_q[C_TXEN] & ~tf_empty;

  uart_tx_ser u_tx (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .in_valid(tx_valid), .in_ready(tx_ready), .in_data(tf_rdata),
    .par_en(ctrl_q[C_PEN]), .odd(ctrl_q[C_ODD]),
    .txd(tx_line), .done(tx_done));

  assign txd    = ctrl_q[C_LOOP] ? 1'b1 : tx_line;
  assign rx_src = ctrl_q[C_LOOP] ? tx_line : rxd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin rx_s1 <= 1'b1; rx_s2 <= 1'b1; end
    else        begin rx_s1 <= rx_src; rx_s2 <= rx_s1; end
  end

  uart_rx_ser u_rx (
    .clk(clk), .rst_n(rst_n), .tick(tick), .en(ctrl_q[C_RXEN]), .line(rx_s2),
    .par_en(ctrl_q[C_PEN]), .odd(ctrl_q[C_ODD]),
    .out_valid(rx_valid), .out_data(rx_data), .par_err(rx_perr), .frm_err(rx_ferr));

  uart_fifo_buf #(.W(8), .DEPTH(DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n),
    .push(rx_valid & ~rf_full), .wdata(rx_data),
    .pop(rd && paddr == A_DATA), .rdata(rf_rdata),
    .count(rf_cnt), .full(rf_full), .empty(rf_empty));

  // sticky error bits; a new event in the clearing cycle wins
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_ovr <= 1'b0; st_perr <= 1'b0; st_ferr <= 1'b0;
    end else begin
      if (wr && paddr == A_STAT) begin
        st_ovr <= 1'b0; st_perr <= 1'b0; st_ferr <= 1'b0;
      end
      if (rx_valid && rf_full) st_ovr  <= 1'b1;
      if (rx_perr)             st_perr <= 1'b1;
      if (rx_ferr)             st_ferr <= 1'b1;
    end
  end

  assign tx_half = (tf_cnt <= CW'(DEPTH/2));
  assign rx_half = (rf_cnt >= CW'(DEPTH/2));

  always_comb begin
    stat        = '0;
    stat[0]     = ~rf_empty;
    stat[1]     = tx_ready;
    stat[2]     = tf_empty;
    stat[4]     = st_ovr;
    stat[5]     = st_perr;
    stat[6]     = st_ferr;
    stat[7]     = tx_half;
    stat[8]     = rx_half;
    stat[9]     = tf_full;
    stat[10]    = rf_full;
    stat[25:20] = 6'(tf_cnt);
    stat[31:26] = 6'(rf_cnt);
  end

  always_comb begin
    prdata = '0;
    unique case (paddr)
      A_DATA:  prdata = rf_empty ? 32'd0 : {24'd0, rf_rdata};
      A_STAT:  prdata = stat;
      A_CTRL:  prdata = {{(32-CTRL_W){1'b0}}, ctrl_q};
      A_DIV:   prdata = {{(32-SCALER_W){1'b0}}, div_q};
      default: prdata = '0;
    endcase
  end

  assign irq = (ctrl_q[C_RIE]  & rx_valid) |
               (ctrl_q[C_TIE]  & tx_done)  |
               (ctrl_q[C_TFIE] & tx_half)  |
               (ctrl_q[C_RFIE] & rx_half);

  AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(st_ovr) && !$past(wr && paddr == A_STAT)) |-> st_ovr); // R8
  AST_TX_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(tf_cnt) == tf_cnt + 1'b1 && !$past(wr && paddr == A_DATA)) |-> $past(ctrl_q[C_TXEN])); // R3
endmodule

// File: tb/test_uart_fifo_periph.sv
module test_uart_fifo_periph;
  localparam int DEPTH = 8;
  localparam int S     = 1;
  localparam int BITP  = 8*(S+1);

  logic clk = 1'b0, rst_n = 1'b0;
  logic psel = 0, penable = 0, pwrite = 0;
  logic [3:0] paddr = '0;
  logic [31:0] pwdata = '0, prdata;
  logic rxd = 1'b1, txd, irq;

  int checks = 0, errors = 0, irq_hi = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  uart_fifo_periph #(.DEPTH(DEPTH)) i_uart_fifo_periph (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .rxd(rxd), .txd(txd), .irq(irq));

  // {parity enable, odd, byte}
  localparam logic [9:0] VEC [9] = '{
    {2'b00, 8'h00}, {2'b00, 8'hFF}, {2'b00, 8'hA5},
    {2'b10, 8'h3C}, {2'b10, 8'h01}, {2'b10, 8'h80},
    {2'b11, 8'h5A}, {2'b11, 8'hFE}, {2'b11, 8'h7F}};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); psel = 1; pwrite = 1; paddr = a; pwdata = d; penable = 0;
    @(negedge clk); penable = 1;
    @(negedge clk); psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk); psel = 1; pwrite = 0; paddr = a; penable = 0;
    @(negedge clk); penable = 1; d = prdata;
    @(negedge clk); psel = 0; penable = 0;
  endtask

  task automatic wait_stat(input logic [31:0] mask, input logic [31:0] val, output logic [31:0] s);
    for (int i = 0; i < 3000; i++) begin
      rd(4'h4, s);
      if ((s & mask) == val) return;
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin @(negedge clk); if (irq) irq_hi++; end
  endtask

  task automatic send(input logic [7:0] b, input bit usep, input bit pb, input bit stopb);
    logic [10:0] f;
    int nb;
    f  = usep ? {stopb, pb, b, 1'b0} : {1'b1, stopb, b, 1'b0};
    nb = usep ? 11 : 10;
    for (int k = 0; k < nb; k++) begin
      rxd = f[k];
      for (int c = 0; c < BITP; c++) begin @(negedge clk); if (irq) irq_hi++; end
    end
    rxd = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] s, d;
    logic [7:0] bytes [DEPTH+1];
    logic [10:0] fr;
    int nb;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rd(4'h4, s);
    chk("R1 status", s, 32'h86);
    chk("R1 txd", {31'd0, txd}, 1);
    chk("R1 irq", {31'd0, irq}, 0);

    wr(4'h8, 32'hFFF); rd(4'h8, d); chk("R2 control", d, 32'h6FF);
    wr(4'h8, 32'h0);
    wr(4'hC, S);       rd(4'hC, d); chk("R2 divider", d, S);

    // R3 / R7: accumulate with transmitter disabled
    for (int i = 0; i <= DEPTH; i++) begin
      bytes[i] = 8'(8'h31 + 8'(i*29));
      wr(4'h0, {24'd0, bytes[i]});
      rd(4'h4, s);
      chk("R3 tx count", {26'd0, s[25:20]}, (i < DEPTH) ? i+1 : DEPTH);
      chk("R7 tx half", {31'd0, s[7]}, ((i < DEPTH ? i+1 : DEPTH) <= DEPTH/2) ? 1 : 0);
    end
    chk("R3 tx full", {31'd0, s[9]}, 1);
    chk("R3 txd idle", {31'd0, txd}, 1);

    // R5 / R6 / R7: loopback drains the queue into the receiver
    wr(4'h8, 32'h83);
    idle(200);
    chk("R5 txd held in loopback", {31'd0, txd}, 1);
    wait_stat(32'hFC00_0000, DEPTH << 26, s);
    chk("R7 rx count full", {26'd0, s[31:26]}, DEPTH);
    chk("R7 rx flags", {29'd0, s[10], s[8], s[0]}, 3'b111);
    for (int i = 0; i < DEPTH; i++) begin
      rd(4'h0, d);
      chk("R5 loopback order", d, {24'd0, bytes[i]});
      rd(4'h4, s);
      chk("R6 rx count", {26'd0, s[31:26]}, DEPTH-1-i);
      chk("R7 rx half", {31'd0, s[8]}, (DEPTH-1-i >= DEPTH/2) ? 1 : 0);
    end
    chk("R6 drained flags", {29'd0, s[10], s[8], s[0]}, 0);
    rd(4'h0, d); chk("R6 empty read", d, 0);

    // R8: overrun
    for (int i = 0; i <= DEPTH; i++) wr(4'h0, {24'd0, bytes[i]});
    wait_stat(32'h10, 32'h10, s);
    chk("R8 overrun bit", {31'd0, s[4]}, 1);
    chk("R8 rx count after drop", {26'd0, s[31:26]}, DEPTH);
    wr(4'h4, 0); rd(4'h4, s);
    chk("R8 clear", {29'd0, s[6:4]}, 0);
    for (int i = 0; i < DEPTH; i++) begin
      rd(4'h0, d); chk("R8 kept data", d, {24'd0, bytes[i]});
    end

    // R4 / R5: table walk over parity settings in loopback
    for (int v = 0; v < 9; v++) begin
      wr(4'h8, 32'h83 | (VEC[v][9] ? 32'h20 : 0) | (VEC[v][8] ? 32'h10 : 0));
      wr(4'h0, {24'd0, VEC[v][7:0]});
      wait_stat(32'h1, 32'h1, s);
      rd(4'h0, d);
      chk("R5 table byte", d, {24'd0, VEC[v][7:0]});
      rd(4'h4, s);
      chk("R4 table parity ok", {31'd0, s[5]}, 0);
    end

    // R4 / R11: external frame timing and transmit-done interrupt
    wr(4'h8, 32'h2A);
    irq_hi = 0;
    wr(4'h0, 32'hA7);
    nb = 0;
    while (txd !== 1'b0 && nb < 100) begin @(negedge clk); nb++; end
    fr = {1'b1, 1'b1, 8'hA7, 1'b0};
    for (int c = 0; c < 240; c++) begin
      if ((c % BITP) == BITP/2 && c / BITP < 11)
        chk("R4 frame bit", {31'd0, txd}, {31'd0, fr[c / BITP]});
      if (irq) irq_hi++;
      @(negedge clk);
    end
    chk("R11 tx done pulse", irq_hi, 1);

    // R9: parity error stored, frame error dropped
    wr(4'h8, 32'h21);
    send(8'h0F, 1, 1, 1); idle(40);
    rd(4'h4, s);
    chk("R9 parity sticky", {31'd0, s[5]}, 1);
    chk("R9 parity frame kept", {26'd0, s[31:26]}, 1);
    rd(4'h0, d); chk("R9 parity data", d, 32'h0F);
    wr(4'h4, 0);
    wr(4'h8, 32'h01);
    send(8'h55, 0, 0, 0); idle(60);
    rd(4'h4, s);
    chk("R9 frame sticky", {31'd0, s[6]}, 1);
    chk("R9 frame dropped", {26'd0, s[31:26]}, 0);
    wr(4'h4, 0);

    // R11: receive pulse
    wr(4'h8, 32'h05);
    irq_hi = 0;
    send(8'h3C, 0, 0, 1); idle(40);
    chk("R11 rx pulse", irq_hi, 1);
    rd(4'h0, d); chk("R11 rx data", d, 32'h3C);

    // R10: receiver off
    wr(4'h8, 32'h00);
    send(8'h5A, 0, 0, 1); idle(40);
    rd(4'h4, s);
    chk("R10 ignored", {26'd0, s[31:26]}, 0);

    // R11: level sources
    wr(4'h8, 32'h200); @(negedge clk);
    chk("R11 tx half level", {31'd0, irq}, 1);
    wr(4'h8, 32'h400); @(negedge clk);
    chk("R11 rx half low", {31'd0, irq}, 0);
    wr(4'h8, 32'h0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule